// File: doc/BRIEF.md
# Byte-to-Longword DMA Burst Engine

This block is the data path of a DMA channel that takes bytes from an 8-bit peripheral port and writes them to a 32-bit local bus. Bytes are accepted through a valid/ready handshake. They are assembled into longwords, with the earliest byte in the most significant lane, and each longword is pushed into a small FIFO together with its byte enables. A bus-master sequencer empties the FIFO in four-longword bursts. It asks for the bus only when a whole burst is buffered, and it paces the leading beat by the parity mode that was latched when the transfer started.

Software loads a longword-aligned destination address, a byte count and the parity mode, then pulses `start`. Once the peripheral has delivered every byte, the longwords left over (fewer than a burst) go out as single-beat cycles. The last of these may be partial and then carries only its valid byte enables. A `done` flag rises once every byte has been written.

The sequencer has five states. `S_IDLE` waits for `start`: a non-zero count moves it to `S_COLLECT`, and a zero count sets `done` at once. `S_COLLECT` returns to `S_IDLE` with `done` set once the remaining count is zero. It moves to `S_REQ` when a burst is buffered, or when input is drained and the FIFO is non-empty. `S_REQ` holds `bus_req` until `bus_gnt`, then enters `S_LEAD`. `S_LEAD` counts the leading-beat latency and transfers the first longword on its last cycle. From there a burst goes to `S_STREAM` and a single cycle goes back to `S_COLLECT`. `S_STREAM` transfers one longword per clock and returns to `S_COLLECT` after the last beat of the burst.

Top module: `pbd_top`

## Requirements
- R1: Bytes are packed big-endian: the first byte of each group of four lands in `bus_data[31:24]`, the fourth in `bus_data[7:0]`.
- R2: `in_ready` is low in reset, while idle, once all bytes of the transfer have been accepted, and whenever the FIFO is full. A byte is taken only in a cycle with `in_valid` and `in_ready` both high.
- R3: A burst request is raised only when at least four longwords are buffered. While input is still pending and fewer are buffered, `bus_req` stays low.
- R4: `bus_req` stays high until `bus_gnt` is seen. No beat and no `bus_cyc` occur without a grant.
- R5: The leading beat falls on the 4th cycle of `bus_cyc` with parity off and on the 5th cycle with parity on. The mode is latched at `start`, and later changes to `parity_en` have no effect on the running transfer.
- R6: The three following beats of a burst come on the three consecutive clocks after the leading beat, each at an address 4 above the one before.
- R7: The destination address advances by 16 after each burst and by 4 after each single cycle, so longword k of the transfer is written at start address + 4k.
- R8: After the last byte is accepted, leftover longwords go out as single cycles with `bus_burst` low. A final partial longword of n bytes has `bus_be` with its top n bits set (`bus_be[3]` is lane 31:24) and zeros in its unused lanes.
- R9: The remaining count drops by the number of enabled bytes per beat. `done` goes high when it reaches zero, is cleared by an accepted `start`, and a zero byte count sets `done` with no bus cycle.
- R10: A `start` pulse while a transfer is running is ignored.
- R11: After reset, `bus_req`, `bus_cyc`, `bus_beat`, `done` and `in_ready` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse to begin a transfer (accepted only when idle) |
| start_addr | input | ADDR_W | Longword-aligned destination address |
| byte_count | input | CNT_W | Bytes to transfer |
| parity_en | input | 1 | Parity mode, latched at start (selects leading latency) |
| in_valid | input | 1 | Peripheral byte valid |
| in_data | input | 8 | Peripheral byte |
| in_ready | output | 1 | Block can accept a byte |
| bus_req | output | 1 | Local bus request |
| bus_gnt | input | 1 | Local bus grant |
| bus_cyc | output | 1 | Bus cycle in progress |
| bus_beat | output | 1 | A longword transfers this clock |
| bus_burst | output | 1 | Current cycle is a four-longword burst |
| bus_addr | output | ADDR_W | Address of the current beat |
| bus_data | output | 32 | Data of the current beat |
| bus_be | output | 4 | Byte enables of the current beat |
| done | output | 1 | Transfer complete |

## Verification
The bench builds the block with `FIFO_DEPTH=4`, `CNT_W=12` and the default latencies of 4 and 5. A FIFO exactly one burst deep fills after sixteen bytes, so the full-FIFO backpressure on `in_ready` appears as soon as the grant is withheld. The byte counts chosen (16, 22, 32 and 0) cover pure bursts, a full single plus a two-byte partial tail, and the zero-length case. One transfer also flips `parity_en` after start, and another receives a stray `start` while busy.

// File: rtl/pbd_pkg.sv
package pbd_pkg;

    localparam int LW_BYTES = 4;

    typedef enum logic [2:0] {
        S_IDLE,
        S_COLLECT,
        S_REQ,
        S_LEAD,
        S_STREAM
    } seq_state_t;

    // number of enabled bytes in a longword enable mask
    function automatic logic [2:0] be_bytes(input logic [3:0] be);
        logic [2:0] n;
        n = 3'd0;
        for (int i = 0; i < LW_BYTES; i++) begin
            n = n + {2'b00, be[i]};
        end
        return n;
    endfunction

endpackage

// File: rtl/pbd_packer.sv
module pbd_packer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_count,
    input  logic             active,
    input  logic             fifo_full,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    output logic             in_ready,
    output logic             push,
    output logic [31:0]      push_data,
    output logic [3:0]       push_be,
    output logic             drained
);

    logic [31:0]      acc;
    logic [1:0]       nheld;
    logic [CNT_W-1:0] left;
    logic             take;
    logic             last_byte;
    logic [31:0]      merged;

    assign in_ready  = active && (left != '0) && !fifo_full;
    assign take      = in_valid && in_ready;
    assign last_byte = (left == CNT_W'(1));
    assign push      = take && ((nheld == 2'd3) || last_byte);
    assign push_data = merged;
    assign drained   = (left == '0);

    always_comb begin
        merged = acc;
        unique case (nheld)
            2'd0: merged[31:24] = in_data;
            2'd1: merged[23:16] = in_data;
            2'd2: merged[15:8]  = in_data;
            2'd3: merged[7:0]   = in_data;
        endcase
    end

    always_comb begin
        unique case (nheld)
            2'd0: push_be = 4'b1000;
            2'd1: push_be = 4'b1100;
            2'd2: push_be = 4'b1110;
            2'd3: push_be = 4'b1111;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc   <= '0;
            nheld <= '0;
            left  <= '0;
        end else if (load) begin
            acc   <= '0;
            nheld <= '0;
            left  <= load_count;
        end else if (take) begin
            left <= left - CNT_W'(1);
            if (push) begin
                acc   <= '0;
                nheld <= '0;
            end else begin
                acc   <= merged;
                nheld <= nheld + 2'd1;
            end
        end
    end

    // R8
    partial_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (push_be inside {4'b1000, 4'b1100, 4'b1110, 4'b1111}));

    // R2
    no_take_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !push);

endmodule

// File: rtl/pbd_fifo.sv
module pbd_fifo #(
    parameter int W     = 36,
    parameter int DEPTH = 8,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic [CW-1:0] count,
    output logic         full,
    output logic         empty
);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;

    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);
    assign head  = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + PW'(1);
            if (pop)  rd_ptr <= rd_ptr + PW'(1);
            unique case ({push, pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R4
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/pbd_burst_seq.sv
module pbd_burst_seq
    import pbd_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int CNT_W     = 16,
    parameter int BURST_LEN = 4,
    parameter int LAT_OFF   = 4,
    parameter int LAT_ON    = 5,
    parameter int FCNT_W    = 4,
    localparam int LAT_MAX  = (LAT_OFF > LAT_ON) ? LAT_OFF : LAT_ON,
    localparam int LAT_W    = $clog2(LAT_MAX + 1),
    localparam int BIDX_W   = $clog2(BURST_LEN),
    localparam int STEP     = BURST_LEN * LW_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  byte_count,
    input  logic              parity_en,
    input  logic [FCNT_W-1:0] fifo_count,
    input  logic              fifo_empty,
    input  logic [3:0]        head_be,
    input  logic              in_drained,
    input  logic              bus_gnt,
    output logic              active,
    output logic              load,
    output logic              pop,
    output logic              bus_req,
    output logic              bus_cyc,
    output logic              bus_beat,
    output logic              bus_burst,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              done
);

    seq_state_t        state;
    seq_state_t        nxt;
    logic [ADDR_W-1:0] base_addr;
    logic [CNT_W-1:0]  rem;
    logic              par_lat;
    logic [LAT_W-1:0]  lat_cnt;
    logic [LAT_W-1:0]  lat_target;
    logic [BIDX_W-1:0] beat_idx;
    logic              is_burst;
    logic              burst_ready;
    logic              tail_ready;
    logic              lead_hit;
    logic              last_beat;

    assign burst_ready = (fifo_count >= FCNT_W'(BURST_LEN));
    assign tail_ready  = in_drained && !fifo_empty;
    assign lat_target  = par_lat ? LAT_W'(LAT_ON) : LAT_W'(LAT_OFF);
    assign lead_hit    = (lat_cnt == lat_target);
    assign last_beat   = (beat_idx == BIDX_W'(BURST_LEN - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:    if (start && (byte_count != '0)) nxt = S_COLLECT;
            S_COLLECT: begin
                if (rem == '0)                     nxt = S_IDLE;
                else if (burst_ready || tail_ready) nxt = S_REQ;
            end
            S_REQ:     if (bus_gnt) nxt = S_LEAD;
            S_LEAD:    if (lead_hit) nxt = is_burst ? S_STREAM : S_COLLECT;
            S_STREAM:  if (last_beat) nxt = S_COLLECT;
            default:   nxt = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        active    = (state != S_IDLE);
        load      = (state == S_IDLE) && start;
        bus_req   = (state == S_REQ);
        bus_cyc   = (state == S_LEAD) || (state == S_STREAM);
        bus_beat  = ((state == S_LEAD) && lead_hit) || (state == S_STREAM);
        bus_burst = bus_cyc && is_burst;
        pop       = bus_beat;
        bus_addr  = base_addr + ADDR_W'({beat_idx, 2'b00});
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_addr <= '0;
            rem       <= '0;
            par_lat   <= 1'b0;
            lat_cnt   <= '0;
            beat_idx  <= '0;
            is_burst  <= 1'b0;
            done      <= 1'b0;
        end else begin
            if (load) begin
                base_addr <= start_addr;
                rem       <= byte_count;
                par_lat   <= parity_en;
                done      <= (byte_count == '0);
                beat_idx  <= '0;
            end
            if ((state == S_COLLECT) && (rem == '0)) begin
                done <= 1'b1;
            end
            if ((state == S_COLLECT) && (nxt == S_REQ)) begin
                is_burst <= burst_ready;
            end
            if ((state == S_REQ) && bus_gnt) begin
                lat_cnt <= LAT_W'(1);
            end else if (state == S_LEAD) begin
                lat_cnt <= lat_cnt + LAT_W'(1);
            end
            if (bus_beat) begin
                rem <= rem - CNT_W'(be_bytes(head_be));
            end
            if ((state == S_LEAD) && lead_hit) begin
                if (is_burst) beat_idx  <= BIDX_W'(1);
                else          base_addr <= base_addr + ADDR_W'(LW_BYTES);
            end
            if (state == S_STREAM) begin
                if (last_beat) begin
                    beat_idx  <= '0;
                    base_addr <= base_addr + ADDR_W'(STEP);
                end else begin
                    beat_idx <= beat_idx + BIDX_W'(1);
                end
            end
        end
    end

    // R3
    burst_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_burst == 1'b0 && is_burst) |-> (fifo_count >= FCNT_W'(BURST_LEN)));

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |=> bus_req);

    // R5
    lead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_cyc) |-> !bus_beat);

    // R6
    beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_beat && (state == S_STREAM)) |-> (bus_addr == $past(bus_addr) + ADDR_W'(LW_BYTES)));

    // R9
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !bus_cyc);

endmodule

// File: rtl/pbd_top.sv
module pbd_top #(
    parameter int ADDR_W     = 32,
    parameter int CNT_W      = 16,
    parameter int FIFO_DEPTH = 8,
    parameter int BURST_LEN  = 4,
    parameter int LAT_OFF    = 4,
    parameter int LAT_ON     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  byte_count,
    input  logic              parity_en,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    output logic              in_ready,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_cyc,
    output logic              bus_beat,
    output logic              bus_burst,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [31:0]       bus_data,
    output logic [3:0]        bus_be,
    output logic              done
);

    localparam int ENT_W  = 32 + 4;
    localparam int FCNT_W = $clog2(FIFO_DEPTH + 1);

    logic              active;
    logic              load;
    logic              push;
    logic [31:0]       push_data;
    logic [3:0]        push_be;
    logic              drained;
    logic              pop;
    logic [ENT_W-1:0]  head;
    logic [FCNT_W-1:0] fcount;
    logic              ffull;
    logic              fempty;

    pbd_packer #(.CNT_W(CNT_W)) u_packer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .load_count (byte_count),
        .active     (active),
        .fifo_full  (ffull),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_ready   (in_ready),
        .push       (push),
        .push_data  (push_data),
        .push_be    (push_be),
        .drained    (drained)
    );

    pbd_fifo #(.W(ENT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data ({push_be, push_data}),
        .pop       (pop),
        .head      (head),
        .count     (fcount),
        .full      (ffull),
        .empty     (fempty)
    );

    pbd_burst_seq #(
        .ADDR_W    (ADDR_W),
        .CNT_W     (CNT_W),
        .BURST_LEN (BURST_LEN),
        .LAT_OFF   (LAT_OFF),
        .LAT_ON    (LAT_ON),
        .FCNT_W    (FCNT_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_addr (start_addr),
        .byte_count (byte_count),
        .parity_en  (parity_en),
        .fifo_count (fcount),
        .fifo_empty (fempty),
        .head_be    (head[35:32]),
        .in_drained (drained),
        .bus_gnt    (bus_gnt),
        .active     (active),
        .load       (load),
        .pop        (pop),
        .bus_req    (bus_req),
        .bus_cyc    (bus_cyc),
        .bus_beat   (bus_beat),
        .bus_burst  (bus_burst),
        .bus_addr   (bus_addr),
        .done       (done)
    );

    assign bus_data = head[31:0];
    assign bus_be   = head[35:32];

endmodule

// File: tb/pbd_top_bench.sv
module pbd_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] start_addr = '0;
    logic [11:0] byte_count = '0;
    logic        parity_en = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_ready;
    logic        bus_req;
    logic        bus_gnt;
    logic        bus_cyc;
    logic        bus_beat;
    logic        bus_burst;
    logic [31:0] bus_addr;
    logic [31:0] bus_data;
    logic [3:0]  bus_be;
    logic        done;
    logic        gnt_en = 1'b1;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    assign bus_gnt = bus_req & gnt_en;

    pbd_top #(.ADDR_W(32), .CNT_W(12), .FIFO_DEPTH(4)) u_pbd_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_addr (start_addr),
        .byte_count (byte_count),
        .parity_en  (parity_en),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_ready   (in_ready),
        .bus_req    (bus_req),
        .bus_gnt    (bus_gnt),
        .bus_cyc    (bus_cyc),
        .bus_beat   (bus_beat),
        .bus_burst  (bus_burst),
        .bus_addr   (bus_addr),
        .bus_data   (bus_data),
        .bus_be     (bus_be),
        .done       (done)
    );

    // beat monitor
    logic [31:0] mon_addr  [0:63];
    logic [31:0] mon_data  [0:63];
    logic [3:0]  mon_be    [0:63];
    logic        mon_burst [0:63];
    int          mon_pos   [0:63];
    int          mon_n = 0;
    int          cyc_pos = 0;
    int          bad_beat = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            cyc_pos = 0;
        end else begin
            if (bus_cyc) cyc_pos = cyc_pos + 1;
            else         cyc_pos = 0;
            if (bus_beat && !bus_cyc) bad_beat = bad_beat + 1;
            if (bus_beat && mon_n < 64) begin
                mon_addr[mon_n]  = bus_addr;
                mon_data[mon_n]  = bus_data;
                mon_be[mon_n]    = bus_be;
                mon_burst[mon_n] = bus_burst;
                mon_pos[mon_n]   = cyc_pos;
                mon_n = mon_n + 1;
            end
        end
    end

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'((seed + i * 13) & 255);
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_start(input logic [31:0] a, input int n, input logic par);
        @(negedge clk);
        mon_n      = 0;
        start_addr = a;
        byte_count = 12'(n);
        parity_en  = par;
        start      = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic feed(input int seed, input int from, input int n);
        for (int i = from; i < from + n; i++) begin
            in_valid = 1'b1;
            in_data  = pat(seed, i);
            while (!in_ready) @(negedge clk);
            @(negedge clk);
        end
        in_valid = 1'b0;
    endtask

    task automatic wait_done();
        int k;
        k = 0;
        while (!done && k < 3000) begin
            @(negedge clk);
            k++;
        end
    endtask

    // expected beats computed from the requirements
    task automatic verify(input logic [31:0] a, input int n, input int seed, input int lat);
        int nlw;
        int nburst_lw;
        nlw       = (n + 3) / 4;
        nburst_lw = (n / 16) * 4;
        chk("R9", "done", 32'(done), 32'd1);
        chk("R7", "beat count", 32'(mon_n), 32'(nlw));
        chk("R2", "ready after all bytes", 32'(in_ready), 32'd0);
        for (int k = 0; k < nlw && k < mon_n; k++) begin
            logic [31:0] ed;
            logic [3:0]  eb;
            int          nb;
            nb = (n - 4 * k) >= 4 ? 4 : (n - 4 * k);
            ed = '0;
            eb = '0;
            for (int b = 0; b < nb; b++) begin
                ed[31 - 8 * b -: 8] = pat(seed, 4 * k + b);
                eb[3 - b] = 1'b1;
            end
            chk("R7", "addr", mon_addr[k], a + 32'(4 * k));
            chk("R1", "data", mon_data[k], ed);
            chk("R8", "byte enables", 32'(mon_be[k]), 32'(eb));
            chk("R8", "burst flag", 32'(mon_burst[k]), 32'(k < nburst_lw));
            if (k < nburst_lw)
                chk("R6", "beat position", 32'(mon_pos[k]), 32'(lat + (k % 4)));
            else
                chk("R5", "single position", 32'(mon_pos[k]), 32'(lat));
        end
    endtask

    task automatic t_reset();
        chk("R11", "bus_req", 32'(bus_req), 32'd0);
        chk("R11", "bus_cyc", 32'(bus_cyc), 32'd0);
        chk("R11", "bus_beat", 32'(bus_beat), 32'd0);
        chk("R11", "done", 32'(done), 32'd0);
        chk("R2", "in_ready idle", 32'(in_ready), 32'd0);
    endtask

    task automatic t_burst_off();
        do_start(32'h0000_1000, 32, 1'b0);
        feed(3, 0, 32);
        wait_done();
        verify(32'h0000_1000, 32, 3, 4);
    endtask

    task automatic t_parity_on();
        do_start(32'h0000_2000, 16, 1'b1);
        chk("R9", "done cleared by start", 32'(done), 32'd0);
        parity_en = 1'b0;   // R5: must not affect running transfer
        feed(40, 0, 16);
        wait_done();
        verify(32'h0000_2000, 16, 40, 5);
    endtask

    task automatic t_tail();
        do_start(32'h0000_3000, 22, 1'b0);
        feed(77, 0, 22);
        wait_done();
        verify(32'h0000_3000, 22, 77, 4);
    endtask

    task automatic t_hold();
        int reqs;
        do_start(32'h0000_4000, 32, 1'b0);
        feed(9, 0, 12);
        reqs = 0;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if (bus_req || bus_cyc) reqs++;
            if (c == 5) begin
                start_addr = 32'hDEAD_0000;   // R10 stray start
                byte_count = 12'd4;
                start      = 1'b1;
            end
            if (c == 6) start = 1'b0;
        end
        chk("R3", "no request below a burst", 32'(reqs), 32'd0);
        feed(9, 12, 20);
        wait_done();
        verify(32'h0000_4000, 32, 9, 4);
        chk("R10", "stray start ignored, beats", 32'(mon_n), 32'd8);
    endtask

    task automatic t_backpressure();
        int taken;
        gnt_en = 1'b0;
        do_start(32'h0000_5000, 32, 1'b0);
        taken = 0;
        in_valid = 1'b1;
        for (int c = 0; c < 40; c++) begin
            logic acc;
            in_data = pat(21, taken);
            acc = in_ready;
            @(negedge clk);
            if (acc) taken++;
        end
        in_valid = 1'b0;
        chk("R2", "bytes accepted into full fifo", 32'(taken), 32'd16);
        chk("R2", "in_ready when full", 32'(in_ready), 32'd0);
        chk("R4", "bus_req held", 32'(bus_req), 32'd1);
        chk("R4", "no cycle without grant", 32'(mon_n), 32'd0);
        gnt_en = 1'b1;
        feed(21, 16, 16);
        wait_done();
        verify(32'h0000_5000, 32, 21, 4);
    endtask

    task automatic t_zero();
        do_start(32'h0000_6000, 0, 1'b0);
        repeat (3) @(negedge clk);
        chk("R9", "zero count done", 32'(done), 32'd1);
        chk("R9", "zero count beats", 32'(mon_n), 32'd0);
        chk("R2", "zero count ready", 32'(in_ready), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_burst_off();
        t_parity_on();
        t_tail();
        t_hold();
        t_backpressure();
        t_zero();
        chk("R4", "beat outside cycle", 32'(bad_beat), 32'd0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule